// File: doc/BRIEF.md
# Multi-Class Register Rename Map

This block keeps the architectural-to-physical register mapping for an out-of-order core. The register name space has four classes: integer, floating point, condition code and miscellaneous. Each of the first three classes has its own mapping table and its own pool of free physical registers. The miscellaneous class is hardwired: register i always maps to physical i and is never renamed.

A rename request names a class and an index. It returns the register's current mapping, so that it can be released at commit, together with a fresh physical register taken from that class's pool. The integer and floating-point classes each have one hardwired zero register that is never renamed. A combinational lookup port reads a mapping without changing it. A set-entry port writes a mapping directly for squash recovery or commit. A release port returns freed physical registers to a class pool.

Top module: `class_rename_map`

## Requirements
- R1: After reset, architectural register i of every class maps to physical i. Each renamable class pool holds the indices ARCH..PHYS-1 of that class in ascending order.
- R2: A rename with ren_valid set drives the current mapping on ren_old_phys and the new register on ren_new_phys in the same cycle. The table entry takes the new value at the next clock edge.
- R3: A pool hands out registers in first-in, first-out order. A released register is queued behind the registers already in the pool.
- R4: A rename of the integer zero register (index INT_ZERO) or the floating-point zero register (index FP_ZERO) returns that index as both the new and the old mapping and takes nothing from the pool. A set-entry to a zero register leaves it unchanged.
- R5: The condition-code class has no zero register, so every accepted condition-code rename takes a pool entry, index 0 included.
- R6: Class codes are 0 integer, 1 floating point, 2 condition code and 3 miscellaneous. Codes 4 to 7, or an index at or beyond the class's architectural count, raise that port's error output (ren_err, lk_err, set_err) and change no state. A rename flagged this way is not accepted.
- R7: A miscellaneous-class rename is accepted and returns the index as both the new and the old mapping, with no pool use. A lookup of miscellaneous register i returns i.
- R8: A miscellaneous-class set-entry changes nothing. It raises set_err when set_phys differs from the index.
- R9: A set-entry to a renamable non-zero register overwrites its mapping, and a lookup shows the new value from the next cycle.
- R10: When a rename needs a pool entry and that class's pool is empty, ren_ready stays low and neither the table nor the pool changes.
- R11: A set-entry has priority. While set_valid is high, ren_ready is low and the rename has no effect.
- R12: Lookup is combinational and never changes state.
- R13: free_valid with class 0, 1 or 2 appends free_phys to that class's pool. With class 3 or an unknown code, the release is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ren_valid | input | 1 | Rename request |
| ren_class | input | 3 | Class of the renamed register |
| ren_idx | input | AW | Architectural index within the class |
| ren_ready | output | 1 | Rename accepted this cycle |
| ren_new_phys | output | PW | Newly assigned physical register |
| ren_old_phys | output | PW | Mapping being replaced |
| ren_err | output | 1 | Bad class or index on the rename port |
| lk_class | input | 3 | Lookup class |
| lk_idx | input | AW | Lookup index |
| lk_phys | output | PW | Current mapping |
| lk_err | output | 1 | Bad class or index on the lookup port |
| set_valid | input | 1 | Direct mapping write |
| set_class | input | 3 | Class written |
| set_idx | input | AW | Index written |
| set_phys | input | PW | Physical register to install |
| set_err | output | 1 | Bad class or index, or miscellaneous mismatch |
| free_valid | input | 1 | Release a physical register |
| free_class | input | 3 | Pool receiving the release |
| free_phys | input | PW | Released physical register |

## Verification
The assertions assume that a release never targets a pool that is already full, which holds when only mappings previously returned as old values are released. They also assume the block sees no rename or release before reset has run. The bench releases only old mappings that the block itself returned, so pool occupancy never exceeds its depth. It holds reset for several cycles before any request.

// File: rtl/crm_pkg.sv
package crm_pkg;
    // Width of the class code carried on every port
    localparam int CLS_W = 3;
    // Classes with a mapping table and a pool (integer, float, condition code)
    localparam int NUM_RENAMED = 3;

    typedef enum logic [CLS_W-1:0] {
        CLS_INT  = 3'd0,
        CLS_FP   = 3'd1,
        CLS_CC   = 3'd2,
        CLS_MISC = 3'd3
    } reg_class_e;

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/crm_free_pool.sv
// Free physical register pool for one class, kept as a circular FIFO.
// Assumes pops only when not empty and pushes only of registers that
// were handed out earlier, so the pool never overflows.
module crm_free_pool #(
    parameter int DEPTH = 8,
    parameter int FIRST = 8,
    parameter int PW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [PW-1:0] push_val,
    input  logic          pop,
    output logic [PW-1:0] head,
    output logic          empty,
    output logic          full
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [PW-1:0] slots [DEPTH];
    logic [IW-1:0] rd_ptr;
    logic [IW-1:0] wr_ptr;
    logic [CW-1:0] count;
    logic          do_pop;
    logic          do_push;

    function automatic logic [IW-1:0] bump(logic [IW-1:0] p);
        return (p == IW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign head    = slots[rd_ptr];

    // Pool storage, pointers and occupancy; reset fills ARCH..PHYS-1 ascending
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) slots[i] <= PW'(FIRST + i);
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= CW'(DEPTH);
        end else begin
            if (do_push) begin
                slots[wr_ptr] <= push_val;
                wr_ptr        <= bump(wr_ptr);
            end
            if (do_pop) rd_ptr <= bump(rd_ptr);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    assert_pop_has_entry_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    assert_no_overflow_R13: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (!full || pop));
    assert_last_pop_empties_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && count == CW'(1)) |=> empty);
endmodule

// File: rtl/crm_map_table.sv
// Architectural-to-physical mapping table for one renamable class.
// One write port, two combinational read ports. If HAS_ZERO is set,
// entry ZERO_IDX is hardwired and ignores writes.
module crm_map_table #(
    parameter int ARCH     = 8,
    parameter int AW       = 3,
    parameter int PW       = 4,
    parameter int HAS_ZERO = 1,
    parameter int ZERO_IDX = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_a_idx,
    output logic [PW-1:0] rd_a,
    input  logic [AW-1:0] rd_b_idx,
    output logic [PW-1:0] rd_b,
    input  logic          we,
    input  logic [AW-1:0] wr_idx,
    input  logic [PW-1:0] wr_val
);
    localparam int TW = (ARCH > 1) ? $clog2(ARCH) : 1;

    logic [PW-1:0] entries [ARCH];
    logic          wr_ok;

    assign rd_a  = (int'(rd_a_idx) < ARCH) ? entries[rd_a_idx[TW-1:0]] : '0;
    assign rd_b  = (int'(rd_b_idx) < ARCH) ? entries[rd_b_idx[TW-1:0]] : '0;
    assign wr_ok = we && (int'(wr_idx) < ARCH)
                   && !((HAS_ZERO != 0) && (int'(wr_idx) == ZERO_IDX));

    // Identity mapping on reset, single-entry update otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ARCH; i++) entries[i] <= PW'(i);
        end else if (wr_ok) begin
            entries[wr_idx[TW-1:0]] <= wr_val;
        end
    end

    assert_write_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |=> (rd_b_idx != $past(wr_idx)) || (rd_b == $past(wr_val)));

    if (HAS_ZERO != 0) begin : g_zero
        assert_zero_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (we && int'(wr_idx) == ZERO_IDX) |=> $stable(entries[ZERO_IDX]));
    end
endmodule

// File: rtl/crm_class_slice.sv
// One renamable class: its mapping table plus its free pool.
// Assumes the top raises ren_fire only when the rename is accepted
// (no set-entry this cycle, pool entry available when needed).
module crm_class_slice #(
    parameter int ARCH     = 8,
    parameter int PHYS     = 16,
    parameter int HAS_ZERO = 1,
    parameter int ZERO_IDX = 0,
    parameter int AW       = 3,
    parameter int PW       = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ren_idx,
    input  logic          ren_fire,
    output logic          ren_need,
    output logic [PW-1:0] ren_new,
    output logic [PW-1:0] ren_old,
    output logic          pool_empty,
    input  logic [AW-1:0] lk_idx,
    output logic [PW-1:0] lk_map,
    input  logic          set_we,
    input  logic [AW-1:0] set_idx,
    input  logic [PW-1:0] set_val,
    input  logic          free_push,
    input  logic [PW-1:0] free_val
);
    logic [PW-1:0] pool_head;
    logic          pool_full;
    logic          pop;
    logic          tbl_we;
    logic [AW-1:0] tbl_idx;
    logic [PW-1:0] tbl_val;

    // A hardwired zero register needs no fresh physical register
    assign ren_need = !((HAS_ZERO != 0) && (int'(ren_idx) == ZERO_IDX));
    assign ren_new  = ren_need ? pool_head : PW'(ZERO_IDX);
    assign pop      = ren_fire && ren_need && !set_we;

    // Set-entry has the write port ahead of a rename
    always_comb begin
        tbl_we  = set_we || pop;
        tbl_idx = set_we ? set_idx : ren_idx;
        tbl_val = set_we ? set_val : pool_head;
    end

    crm_map_table #(
        .ARCH(ARCH), .AW(AW), .PW(PW), .HAS_ZERO(HAS_ZERO), .ZERO_IDX(ZERO_IDX)
    ) u_table (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(ren_idx), .rd_a(ren_old),
        .rd_b_idx(lk_idx), .rd_b(lk_map),
        .we(tbl_we), .wr_idx(tbl_idx), .wr_val(tbl_val)
    );

    crm_free_pool #(
        .DEPTH(PHYS - ARCH), .FIRST(ARCH), .PW(PW)
    ) u_pool (
        .clk(clk), .rst_n(rst_n),
        .push(free_push), .push_val(free_val),
        .pop(pop), .head(pool_head), .empty(pool_empty), .full(pool_full)
    );

    assert_fire_has_reg_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_fire && ren_need) |-> !pool_empty);
    assert_one_writer_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_we && ren_fire));
    assert_zero_echo_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_fire && !ren_need) |-> (ren_new == ren_old));
endmodule

// File: rtl/class_rename_map.sv
// Multi-class rename map. Decodes the class on each port, routes it to
// the integer, float or condition-code slice, and serves the
// miscellaneous class as a fixed identity map. Assumes releases only
// return registers earlier given out as old mappings.
module class_rename_map
    import crm_pkg::*;
#(
    parameter int INT_ARCH  = 8,
    parameter int INT_PHYS  = 16,
    parameter int INT_ZERO  = 0,
    parameter int FP_ARCH   = 8,
    parameter int FP_PHYS   = 12,
    parameter int FP_ZERO   = 7,
    parameter int CC_ARCH   = 4,
    parameter int CC_PHYS   = 6,
    parameter int MISC_ARCH = 4,
    localparam int AW = $clog2(imax(imax(INT_ARCH, FP_ARCH), imax(CC_ARCH, MISC_ARCH))),
    localparam int PW = $clog2(imax(imax(INT_PHYS, FP_PHYS), imax(CC_PHYS, MISC_ARCH)))
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ren_valid,
    input  logic [CLS_W-1:0] ren_class,
    input  logic [AW-1:0]    ren_idx,
    output logic             ren_ready,
    output logic [PW-1:0]    ren_new_phys,
    output logic [PW-1:0]    ren_old_phys,
    output logic             ren_err,
    input  logic [CLS_W-1:0] lk_class,
    input  logic [AW-1:0]    lk_idx,
    output logic [PW-1:0]    lk_phys,
    output logic             lk_err,
    input  logic             set_valid,
    input  logic [CLS_W-1:0] set_class,
    input  logic [AW-1:0]    set_idx,
    input  logic [PW-1:0]    set_phys,
    output logic             set_err,
    input  logic             free_valid,
    input  logic [CLS_W-1:0] free_class,
    input  logic [PW-1:0]    free_phys
);
    // Architectural count of a class; zero for an unknown code
    function automatic int arch_of(logic [CLS_W-1:0] c);
        case (c)
            CLS_INT:  return INT_ARCH;
            CLS_FP:   return FP_ARCH;
            CLS_CC:   return CC_ARCH;
            CLS_MISC: return MISC_ARCH;
            default:  return 0;
        endcase
    endfunction

    logic [PW-1:0]          sl_new [NUM_RENAMED];
    logic [PW-1:0]          sl_old [NUM_RENAMED];
    logic [PW-1:0]          sl_lk  [NUM_RENAMED];
    logic [NUM_RENAMED-1:0] sl_need;
    logic [NUM_RENAMED-1:0] sl_empty;
    logic [NUM_RENAMED-1:0] set_we;
    logic [NUM_RENAMED-1:0] free_push;

    logic          ren_addr_ok, lk_addr_ok, set_addr_ok;
    logic          ren_renamable, ren_is_misc, ren_stall, ren_fire;
    logic          sel_need, sel_empty;
    logic [PW-1:0] sel_new, sel_old, sel_lk;

    assign ren_addr_ok   = int'(ren_idx) < arch_of(ren_class);
    assign lk_addr_ok    = int'(lk_idx)  < arch_of(lk_class);
    assign set_addr_ok   = int'(set_idx) < arch_of(set_class);
    assign ren_renamable = int'(ren_class) < NUM_RENAMED;
    assign ren_is_misc   = (ren_class == CLS_MISC);

    // Pick the slice outputs addressed by the rename and lookup classes
    always_comb begin
        sel_new   = '0;
        sel_old   = '0;
        sel_lk    = '0;
        sel_need  = 1'b0;
        sel_empty = 1'b0;
        for (int g = 0; g < NUM_RENAMED; g++) begin
            if (int'(ren_class) == g) begin
                sel_new   = sl_new[g];
                sel_old   = sl_old[g];
                sel_need  = sl_need[g];
                sel_empty = sl_empty[g];
            end
            if (int'(lk_class) == g) sel_lk = sl_lk[g];
        end
    end

    // Rename acceptance: valid address, no set-entry, register available
    always_comb begin
        ren_err   = ren_valid && !ren_addr_ok;
        ren_stall = ren_renamable && sel_need && sel_empty;
        ren_ready = ren_valid && ren_addr_ok && !set_valid && !ren_stall;
        ren_fire  = ren_ready && ren_renamable;
        if (ren_renamable) begin
            ren_new_phys = sel_new;
            ren_old_phys = sel_old;
        end else if (ren_is_misc) begin
            ren_new_phys = PW'(ren_idx);
            ren_old_phys = PW'(ren_idx);
        end else begin
            ren_new_phys = '0;
            ren_old_phys = '0;
        end
    end

    // Lookup result and error
    always_comb begin
        lk_err = !lk_addr_ok;
        if (int'(lk_class) < NUM_RENAMED) lk_phys = sel_lk;
        else if (lk_class == CLS_MISC)    lk_phys = PW'(lk_idx);
        else                              lk_phys = '0;
    end

    // Set-entry error: bad address or a miscellaneous value that disagrees
    assign set_err = set_valid && (!set_addr_ok
                     || ((set_class == CLS_MISC) && (set_phys != PW'(set_idx))));

    for (genvar g = 0; g < NUM_RENAMED; g++) begin : g_cls
        localparam int G_ARCH = (g == 0) ? INT_ARCH : (g == 1) ? FP_ARCH : CC_ARCH;
        localparam int G_PHYS = (g == 0) ? INT_PHYS : (g == 1) ? FP_PHYS : CC_PHYS;
        localparam int G_HASZ = (g == 2) ? 0 : 1;
        localparam int G_ZIDX = (g == 0) ? INT_ZERO : (g == 1) ? FP_ZERO : 0;

        assign set_we[g]    = set_valid && set_addr_ok && (int'(set_class) == g);
        assign free_push[g] = free_valid && (int'(free_class) == g);

        crm_class_slice #(
            .ARCH(G_ARCH), .PHYS(G_PHYS), .HAS_ZERO(G_HASZ), .ZERO_IDX(G_ZIDX),
            .AW(AW), .PW(PW)
        ) u_slice (
            .clk(clk), .rst_n(rst_n),
            .ren_idx(ren_idx),
            .ren_fire(ren_fire && (int'(ren_class) == g)),
            .ren_need(sl_need[g]),
            .ren_new(sl_new[g]),
            .ren_old(sl_old[g]),
            .pool_empty(sl_empty[g]),
            .lk_idx(lk_idx),
            .lk_map(sl_lk[g]),
            .set_we(set_we[g]),
            .set_idx(set_idx),
            .set_val(set_phys),
            .free_push(free_push[g]),
            .free_val(free_phys)
        );
    end

    assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        set_valid |-> !ren_ready);
    assert_unknown_flagged_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_valid && int'(ren_class) > 3) |-> (ren_err && !ren_ready));
    assert_stall_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_valid && ren_renamable && sel_need && sel_empty) |-> !ren_ready);
    assert_misc_identity_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_ready && ren_is_misc) |-> (ren_new_phys == ren_old_phys));
    assert_lookup_steady_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(lk_class) && $stable(lk_idx) && !$past(ren_fire) && !$past(|set_we))
        |-> $stable(lk_phys));
endmodule

// File: tb/class_rename_map_bench.sv
module class_rename_map_bench;
    localparam int AW = 3;
    localparam int PW = 4;
    localparam int INT_ZERO = 0;
    localparam int FP_ZERO  = 7;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ren_valid, ren_ready, ren_err;
    logic [2:0]    ren_class;
    logic [AW-1:0] ren_idx;
    logic [PW-1:0] ren_new_phys, ren_old_phys;
    logic [2:0]    lk_class;
    logic [AW-1:0] lk_idx;
    logic [PW-1:0] lk_phys;
    logic          lk_err;
    logic          set_valid, set_err;
    logic [2:0]    set_class;
    logic [AW-1:0] set_idx;
    logic [PW-1:0] set_phys;
    logic          free_valid;
    logic [2:0]    free_class;
    logic [PW-1:0] free_phys;

    always #2 clk = ~clk;

    class_rename_map u_class_rename_map (
        .clk(clk), .rst_n(rst_n),
        .ren_valid(ren_valid), .ren_class(ren_class), .ren_idx(ren_idx),
        .ren_ready(ren_ready), .ren_new_phys(ren_new_phys), .ren_old_phys(ren_old_phys),
        .ren_err(ren_err),
        .lk_class(lk_class), .lk_idx(lk_idx), .lk_phys(lk_phys), .lk_err(lk_err),
        .set_valid(set_valid), .set_class(set_class), .set_idx(set_idx),
        .set_phys(set_phys), .set_err(set_err),
        .free_valid(free_valid), .free_class(free_class), .free_phys(free_phys)
    );

    typedef struct {
        string tag;
        bit    chk_ren;
        bit    chk_ids;
        bit    chk_new;
        int    e_ready, e_rerr, e_new, e_old;
        bit    chk_lk;
        int    e_lk, e_lkerr, e_seterr;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;

    // Reference state built from the requirements
    int archs[3] = '{8, 8, 4};
    int physs[3] = '{16, 12, 6};
    int mapm [3][8];
    int fbuf [3][16];
    int fhead[3];
    int fcnt [3];

    function automatic int arch_of(int c);
        if (c < 3)  return archs[c];
        if (c == 3) return 4;
        return 0;
    endfunction

    function automatic bit is_zero(int c, int i);
        return (c == 0 && i == INT_ZERO) || (c == 1 && i == FP_ZERO);
    endfunction

    function automatic int cur_map(int c, int i);
        return (c == 3) ? i : mapm[c][i];
    endfunction

    task automatic model_reset();
        for (int c = 0; c < 3; c++) begin
            for (int i = 0; i < archs[c]; i++) mapm[c][i] = i;
            for (int k = 0; k < physs[c] - archs[c]; k++) fbuf[c][k] = archs[c] + k;
            fhead[c] = 0;
            fcnt[c]  = physs[c] - archs[c];
        end
    endtask

    task automatic chk(string tag, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus, queue the expected outputs, advance the model
    task automatic cyc(int rv, int rc, int ri, int lc, int li,
                       int sv, int sc, int si, int sp,
                       int fv, int fcl, int fp, string tag);
        exp_t e;
        int   need, d, newv;
        bit   rerr, ready;
        @(negedge clk);
        ren_valid  = rv[0];  ren_class = 3'(rc); ren_idx = AW'(ri);
        lk_class   = 3'(lc); lk_idx    = AW'(li);
        set_valid  = sv[0];  set_class = 3'(sc); set_idx = AW'(si); set_phys = PW'(sp);
        free_valid = fv[0];  free_class = 3'(fcl); free_phys = PW'(fp);

        e = '{default: 0, tag: tag};
        rerr  = (ri >= arch_of(rc));
        need  = (rc < 3 && !rerr && !is_zero(rc, ri)) ? 1 : 0;
        ready = rv != 0 && !rerr && sv == 0 && !(need != 0 && fcnt[rc] == 0);
        newv  = 0;
        if (!rerr) begin
            if (rc == 3)          newv = ri;
            else if (need == 0)   newv = ri;
            else if (fcnt[rc] > 0) newv = fbuf[rc][fhead[rc]];
        end
        e.chk_ren = (rv != 0);
        e.e_rerr  = rerr;
        e.e_ready = ready;
        e.chk_ids = (rv != 0) && !rerr;
        e.chk_new = ready;
        e.e_new   = newv;
        e.e_old   = rerr ? 0 : cur_map(rc, ri);
        e.e_lkerr = (li >= arch_of(lc));
        e.chk_lk  = !e.e_lkerr;
        e.e_lk    = e.e_lkerr ? 0 : cur_map(lc, li);
        e.e_seterr = (sv != 0) && (si >= arch_of(sc) || (sc == 3 && sp != si));
        exp_q.push_back(e);

        if (sv != 0 && e.e_seterr == 0 && sc < 3 && !is_zero(sc, si)) begin
            mapm[sc][si] = sp;
        end else if (ready && need != 0) begin
            mapm[rc][ri] = newv;
            d = physs[rc] - archs[rc];
            fhead[rc] = (fhead[rc] + 1) % d;
            fcnt[rc]--;
        end
        if (fv != 0 && fcl < 3) begin
            d = physs[fcl] - archs[fcl];
            fbuf[fcl][(fhead[fcl] + fcnt[fcl]) % d] = fp;
            fcnt[fcl]++;
        end
    endtask

    task automatic look(int lc, int li, string tag);
        cyc(0, 0, 0, lc, li, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic ren(int rc, int ri, string tag);
        cyc(1, rc, ri, rc, ri, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    // Monitor: pop the expected item and compare away from the clock edge
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #1;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                if (e.chk_ren) begin
                    chk(e.tag, "ren_err", int'(ren_err), e.e_rerr);
                    chk(e.tag, "ren_ready", int'(ren_ready), e.e_ready);
                end
                if (e.chk_ids) chk(e.tag, "ren_old_phys", int'(ren_old_phys), e.e_old);
                if (e.chk_new) chk(e.tag, "ren_new_phys", int'(ren_new_phys), e.e_new);
                chk(e.tag, "lk_err", int'(lk_err), e.e_lkerr);
                if (e.chk_lk) chk(e.tag, "lk_phys", int'(lk_phys), e.e_lk);
                chk(e.tag, "set_err", int'(set_err), e.e_seterr);
            end
        end
    end

    initial begin
        #(200000 * 4);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int prev_old, idx, old;
        ren_valid = 0; ren_class = 0; ren_idx = 0; lk_class = 0; lk_idx = 0;
        set_valid = 0; set_class = 0; set_idx = 0; set_phys = 0;
        free_valid = 0; free_class = 0; free_phys = 0;
        rst_n = 1'b0;
        model_reset();
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: identity mapping after reset in every class
        for (int c = 0; c < 4; c++)
            for (int i = 0; i < arch_of(c); i++) look(c, i, "R1 reset map");

        // R2/R3: renames draw from the pool in order
        ren(0, 3, "R2 int rename");
        look(0, 3, "R2 table updated");
        ren(0, 3, "R3 second rename");
        ren(0, 5, "R3 pool order");

        // R4: zero registers
        ren(0, INT_ZERO, "R4 int zero");
        ren(1, FP_ZERO, "R4 fp zero");
        ren(1, 1, "R4 fp pool intact");
        cyc(0, 0, 0, 0, INT_ZERO, 1, 0, INT_ZERO, 5, 0, 0, 0, "R4 set zero");
        look(0, INT_ZERO, "R4 zero unchanged");

        // R5: condition-code index 0 allocates
        ren(2, 0, "R5 cc rename 0");

        // R6: unknown classes and bad indices
        cyc(1, 5, 1, 6, 0, 1, 7, 0, 0, 0, 0, 0, "R6 unknown class");
        ren(2, 5, "R6 cc index out of range");
        look(2, 5, "R6 lookup out of range");

        // R7/R8: miscellaneous class
        ren(3, 2, "R7 misc rename");
        look(3, 3, "R7 misc lookup");
        cyc(0, 0, 0, 3, 1, 1, 3, 1, 1, 0, 0, 0, "R8 misc set match");
        cyc(0, 0, 0, 3, 1, 1, 3, 1, 9, 0, 0, 0, "R8 misc set mismatch");
        look(3, 1, "R8 misc unchanged");

        // R9: direct write
        cyc(0, 0, 0, 0, 3, 1, 0, 3, 3, 0, 0, 0, "R9 set int entry");
        look(0, 3, "R9 set visible");

        // R10: drain condition-code pool, then stall
        ren(2, 1, "R10 cc last entry");
        ren(2, 2, "R10 cc stall");
        look(2, 2, "R10 cc unchanged");

        // R13: release, misc release ignored
        cyc(0, 0, 0, 2, 0, 0, 0, 0, 0, 1, 2, 0, "R13 cc release");
        ren(2, 2, "R13 released reg reused");
        cyc(0, 0, 0, 2, 2, 0, 0, 0, 0, 1, 3, 1, "R13 misc release");
        ren(2, 3, "R13 misc release ignored");

        // R11: set-entry wins over rename
        cyc(1, 1, 2, 1, 2, 1, 1, 2, 3, 0, 0, 0, "R11 set priority");
        look(1, 2, "R11 set applied");
        ren(1, 4, "R11 fp pool untouched");

        // R3/R12: steady rename and release traffic on the integer class
        prev_old = -1;
        for (int k = 0; k < 20; k++) begin
            idx = (k % 7) + 1;
            old = mapm[0][idx];
            cyc(1, 0, idx, 0, (k + 3) % 8, 0, 0, 0, 0,
                (prev_old >= 0) ? 1 : 0, 0, (prev_old >= 0) ? prev_old : 0,
                "R3 rename with release");
            prev_old = old;
        end
        look(1, 1, "R12 lookup only");
        look(1, 1, "R12 lookup repeat");

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule